// File: doc/BRIEF.md
# Tagged Receive Frame Queue

This block is the byte queue that sits between a bit-level HDLC deframer and a host processor. The deframer pushes received bytes into the queue. Each byte carries a tag that says whether it is frame payload or the per-frame status byte written after a frame's last payload byte. The host pops bytes from the head. The head byte and its tag are always visible on the read port, before any pop. Several complete frames, and the start of the next one, can be held at once.

For the host, the queue reports how much it can read. While a status byte is held, the readable count stops at the first status byte, so the host reads exactly one frame at a time. Otherwise the count is the number of payload bytes held. The queue also has an end-of-frame flag and three sticky interrupt flags: fill level reached, status byte written, and overrun.

On overflow the queue never drops data without a trace. The newest entry is replaced by a status byte with its overrun bit set. The rest of that frame is then discarded, and the frame's own status byte is OR-merged into the replaced slot.

Top module: `rx_frame_queue`

## Requirements
- R1: After reset the queue is empty: `avail_cnt` is 0, and `eof_flag`, `irq_fill`, `irq_eof` and `irq_ovr` are all 0.
- R2: Entries are read in write order. `rd_data` and `rd_is_stat` show the head entry without popping it. `rd_en` pops the head one clock later. `rd_en` on an empty queue has no effect.
- R3: With no status byte stored, `avail_cnt` equals the number of stored entries. Otherwise it equals the 1-based position, counted from the head, of the first stored status byte.
- R4: `eof_flag` is 1 exactly while at least one stored entry has its status tag set.
- R5: A write with `wr_is_stat`=1 sets `irq_eof` at that clock edge.
- R6: The fill threshold is `fill_lvl`, where the value 0 stands for 64. `irq_fill` is set at any edge where the stored entry count after that edge is at or above the threshold.
- R7: A write while 64 entries are stored sets `irq_ovr` and leaves the count at 64. If the queue was not already discarding, the newest entry becomes a status entry. Its value is the overrun bit (bit 5, 0x20), OR-ed with the old value if the old entry was a status byte, and OR-ed with the incoming byte if the incoming byte is a status byte.
- R8: After an overrun caused by a payload write, further payload writes are discarded, even if space has been freed. The next status write is OR-merged into the newest stored entry instead of being appended, and it ends the discarding.
- R9: Interrupt flags stay set until `irq_clr` is pulsed. A set condition in the same cycle as `irq_clr` wins.
- R10: With several frames stored, popping through the first status byte moves `avail_cnt` on to the next frame, or to the bare payload count if no further status byte is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe from the deframer |
| wr_data | input | 8 | Byte to write |
| wr_is_stat | input | 1 | 1 marks the written byte as a frame status byte |
| rd_en | input | 1 | Pop the head entry |
| rd_data | output | 8 | Head entry byte |
| rd_is_stat | output | 1 | Head entry status tag |
| avail_cnt | output | 7 | Readable count, 0 to 64 |
| eof_flag | output | 1 | At least one status byte is stored |
| fill_lvl | input | 6 | Fill threshold, 0 means 64 |
| irq_clr | input | 1 | Clears all interrupt flags |
| irq_fill | output | 1 | Sticky fill-level flag |
| irq_eof | output | 1 | Sticky status-written flag |
| irq_ovr | output | 1 | Sticky overrun flag |

## Verification
The readable count is exercised in three situations: payload with no status byte, one complete frame followed by a partial one, and a queue drained across a frame boundary. These separate a count that stops at the first status byte from one that counts every entry. The fill flag is swept over every threshold value, filling from empty to 64 and draining again. This catches off-by-one and wrap errors at the 0-means-64 encoding. Overrun is provoked three ways: a payload write onto payload, a status write onto payload, and a payload write onto an existing status byte. Reading out the merged slot afterwards separates correct OR-merging and discard behaviour from plain overwriting or appending.

// File: rtl/rfq_pkg.sv
package rfq_pkg;
  localparam int BYTE_W  = 8;
  localparam int OVR_BIT = 5;
  localparam logic [BYTE_W-1:0] OVR_MASK = BYTE_W'(1) << OVR_BIT;
endpackage

// File: rtl/rfq_store.sv
module rfq_store #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic             wtag,
  input  logic [DW-1:0]    wdata,
  input  logic [AW-1:0]    ra_addr,
  output logic             ra_tag,
  output logic [DW-1:0]    ra_data,
  input  logic [AW-1:0]    rb_addr,
  output logic             rb_tag,
  output logic [DW-1:0]    rb_data,
  output logic [DEPTH-1:0] tags
);
  logic [DW-1:0]    data_q [DEPTH];
  logic [DEPTH-1:0] tag_q;

  always_ff @(posedge clk) begin
    if (we) begin
      data_q[waddr] <= wdata;
      tag_q[waddr]  <= wtag;
    end
  end

  assign ra_tag  = tag_q[ra_addr];
  assign ra_data = data_q[ra_addr];
  assign rb_tag  = tag_q[rb_addr];
  assign rb_data = data_q[rb_addr];
  assign tags    = tag_q;
endmodule

// File: rtl/rfq_scan.sv
module rfq_scan #(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic [DEPTH-1:0] tags,
  input  logic [AW-1:0]    head,
  input  logic [CW-1:0]    fill,
  output logic             found,
  output logic [AW-1:0]    offset
);
  always_comb begin
    found  = 1'b0;
    offset = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if ((CW'(i) < fill) && tags[head + AW'(i)]) begin
        found  = 1'b1;
        offset = AW'(i);
      end
    end
  end
endmodule

// File: rtl/rx_frame_queue.sv
module rx_frame_queue #(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1,
  localparam int DW   = rfq_pkg::BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_is_stat,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          rd_is_stat,
  output logic [CW-1:0] avail_cnt,
  output logic          eof_flag,
  input  logic [AW-1:0] fill_lvl,
  input  logic          irq_clr,
  output logic          irq_fill,
  output logic          irq_eof,
  output logic          irq_ovr
);
  import rfq_pkg::*;

  logic [AW-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d, newest;
  logic [CW-1:0] cnt_q, cnt_d, stat_q, stat_d, thresh;
  logic          drop_q, drop_d;
  logic          fill_q, fill_d, eofi_q, eofi_d, ovr_q, ovr_d;
  logic          full, pop, push, ovr_hit, merge;
  logic          mem_we, mem_wtag;
  logic [AW-1:0] mem_waddr;
  logic [DW-1:0] mem_wdata;
  logic          head_tag, last_tag;
  logic [DW-1:0] head_data, last_data;
  logic [DEPTH-1:0] tag_vec;
  logic          scan_found;
  logic [AW-1:0] scan_off;

  rfq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk     (clk),
    .we      (mem_we),
    .waddr   (mem_waddr),
    .wtag    (mem_wtag),
    .wdata   (mem_wdata),
    .ra_addr (rd_ptr_q),
    .ra_tag  (head_tag),
    .ra_data (head_data),
    .rb_addr (newest),
    .rb_tag  (last_tag),
    .rb_data (last_data),
    .tags    (tag_vec)
  );

  rfq_scan #(.DEPTH(DEPTH)) u_scan (
    .tags   (tag_vec),
    .head   (rd_ptr_q),
    .fill   (cnt_q),
    .found  (scan_found),
    .offset (scan_off)
  );

  // next-state logic
  always_comb begin
    full    = (cnt_q == CW'(DEPTH));
    newest  = wr_ptr_q - AW'(1);
    pop     = rd_en && (cnt_q != '0);
    push    = wr_en && !full && !drop_q;
    ovr_hit = wr_en && full && !drop_q;
    merge   = wr_en && drop_q && wr_is_stat && (cnt_q != '0);

    mem_we    = push || ovr_hit || merge;
    mem_waddr = push ? wr_ptr_q : newest;
    mem_wtag  = push ? wr_is_stat : 1'b1;
    if (push)
      mem_wdata = wr_data;
    else if (ovr_hit)
      mem_wdata = ({DW{last_tag}} & last_data) | ({DW{wr_is_stat}} & wr_data) | OVR_MASK;
    else
      mem_wdata = last_data | wr_data;

    if (ovr_hit)
      drop_d = !wr_is_stat;
    else if (wr_en && wr_is_stat)
      drop_d = 1'b0;
    else
      drop_d = drop_q;

    wr_ptr_d = wr_ptr_q + AW'(push);
    rd_ptr_d = rd_ptr_q + AW'(pop);
    cnt_d    = cnt_q + CW'(push) - CW'(pop);
    stat_d   = stat_q + CW'(ovr_hit && !last_tag) + CW'(push && wr_is_stat)
             - CW'(pop && head_tag);

    thresh = (fill_lvl == '0) ? CW'(DEPTH) : CW'(fill_lvl);
    fill_d = (fill_q && !irq_clr) || (cnt_d >= thresh);
    eofi_d = (eofi_q && !irq_clr) || (wr_en && wr_is_stat);
    ovr_d  = (ovr_q  && !irq_clr) || (wr_en && full);
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      stat_q   <= '0;
      drop_q   <= 1'b0;
      fill_q   <= 1'b0;
      eofi_q   <= 1'b0;
      ovr_q    <= 1'b0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
      stat_q   <= stat_d;
      drop_q   <= drop_d;
      fill_q   <= fill_d;
      eofi_q   <= eofi_d;
      ovr_q    <= ovr_d;
    end
  end

  assign rd_data    = head_data;
  assign rd_is_stat = head_tag;
  assign eof_flag   = (stat_q != '0);
  assign avail_cnt  = scan_found ? (CW'(scan_off) + CW'(1)) : cnt_q;
  assign irq_fill   = fill_q;
  assign irq_eof    = eofi_q;
  assign irq_ovr    = ovr_q;
endmodule

// File: rtl/rfq_chk.sv
module rfq_chk #(
  parameter int DEPTH = 64,
  parameter int CW    = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          wr_is_stat,
  input logic          rd_en,
  input logic [CW-1:0] cnt_q,
  input logic [CW-1:0] avail_cnt,
  input logic          eof_flag,
  input logic          scan_found,
  input logic          irq_eof,
  input logic          irq_ovr
);
  // R4: status counter agrees with the tag scan
  a_r4_eof_matches_scan: assert property (@(posedge clk) disable iff (!rst_n)
    eof_flag == scan_found);

  // R3: readable count never exceeds stored entries
  a_r3_avail_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    avail_cnt <= cnt_q);

  // R1/R7: occupancy never exceeds depth
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  // R7: write at full raises overrun and keeps the count
  a_r7_ovr_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cnt_q == CW'(DEPTH)) |=> irq_ovr);

  a_r7_count_held: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_en && cnt_q == CW'(DEPTH)) |=> (cnt_q == CW'(DEPTH)));

  // R5: status write raises the end-of-frame interrupt
  a_r5_eof_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_is_stat) |=> irq_eof);

  // R2: a pop without a write lowers the count by one
  a_r2_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CW'(1)));
endmodule

bind rx_frame_queue rfq_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_is_stat (wr_is_stat),
  .rd_en      (rd_en),
  .cnt_q      (cnt_q),
  .avail_cnt  (avail_cnt),
  .eof_flag   (eof_flag),
  .scan_found (scan_found),
  .irq_eof    (irq_eof),
  .irq_ovr    (irq_ovr)
);

// File: tb/rx_frame_queue_tb.sv
module rx_frame_queue_tb;
  localparam int DEPTH = 64;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, wr_is_stat, rd_en, irq_clr;
  logic [7:0] wr_data;
  logic [5:0] fill_lvl;
  logic [7:0] rd_data;
  logic       rd_is_stat, eof_flag, irq_fill, irq_eof, irq_ovr;
  logic [6:0] avail_cnt;

  int n_chk  = 0;
  int n_fail = 0;

  logic [8:0] mq[$];
  bit m_drop, m_fill, m_eof, m_ovr;

  always #4 clk = ~clk;

  rx_frame_queue #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wr_is_stat(wr_is_stat), .rd_en(rd_en), .rd_data(rd_data),
    .rd_is_stat(rd_is_stat), .avail_cnt(avail_cnt), .eof_flag(eof_flag),
    .fill_lvl(fill_lvl), .irq_clr(irq_clr), .irq_fill(irq_fill),
    .irq_eof(irq_eof), .irq_ovr(irq_ovr)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_avail();
    for (int i = 0; i < mq.size(); i++)
      if (mq[i][8]) return i + 1;
    return mq.size();
  endfunction

  function automatic bit exp_eof();
    foreach (mq[i]) if (mq[i][8]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic compare_all();
    chk("R3 avail_cnt", avail_cnt, exp_avail());
    chk("R4 eof_flag", eof_flag, exp_eof());
    chk("R5 irq_eof", irq_eof, m_eof);
    chk("R6 irq_fill", irq_fill, m_fill);
    chk("R7 irq_ovr", irq_ovr, m_ovr);
    if (mq.size() > 0) begin
      chk("R2 head data", rd_data, mq[0][7:0]);
      chk("R2 head tag", rd_is_stat, mq[0][8]);
    end
  endtask

  task automatic step(input bit w, input bit s, input logic [7:0] d,
                      input bit r, input bit c);
    int sz, thr;
    bit full, popv;
    logic [8:0] old;
    logic [7:0] nv;
    @(negedge clk);
    wr_en = w; wr_is_stat = s; wr_data = d; rd_en = r; irq_clr = c;
    @(posedge clk);
    sz   = mq.size();
    full = (sz == DEPTH);
    popv = r && (sz > 0);
    thr  = (fill_lvl == 0) ? DEPTH : int'(fill_lvl);
    if (w) begin
      if (m_drop) begin
        if (s) begin
          if (sz > 0) mq[sz-1] = {1'b1, mq[sz-1][7:0] | d};
          m_drop = 1'b0;
        end
      end else if (full) begin
        old = mq[sz-1];
        nv  = (old[8] ? old[7:0] : 8'h00) | (s ? d : 8'h00) | 8'h20;
        mq[sz-1] = {1'b1, nv};
        m_drop = !s;
      end else begin
        mq.push_back({s, d});
      end
    end
    if (popv) void'(mq.pop_front());
    m_fill = (m_fill && !c) || (mq.size() >= thr);
    m_eof  = (m_eof && !c) || (w && s);
    m_ovr  = (m_ovr && !c) || (w && full);
    #2;
    compare_all();
    wr_en = 1'b0; rd_en = 1'b0; irq_clr = 1'b0;
  endtask

  task automatic drain();
    while (mq.size() > 0) step(0, 0, 8'h00, 1, 0);
  endtask

  initial begin
    #(8 * 190000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 0; wr_is_stat = 0; rd_en = 0; irq_clr = 0;
    wr_data = 8'h00; fill_lvl = 6'd0;
    m_drop = 0; m_fill = 0; m_eof = 0; m_ovr = 0;
    repeat (3) @(posedge clk);
    #2;
    chk("R1 reset avail", avail_cnt, 0);
    chk("R1 reset eof", eof_flag, 0);
    chk("R1 reset irqs", {irq_fill, irq_eof, irq_ovr}, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2: read on empty is ignored
    step(0, 0, 8'h00, 1, 0);
    chk("R2 empty read ignored", avail_cnt, 0);

    // R10: two frames, count stops at the first status byte
    step(1, 0, 8'h11, 0, 0);
    step(1, 0, 8'h22, 0, 0);
    step(1, 0, 8'h33, 0, 0);
    step(1, 1, 8'h00, 0, 0);
    step(1, 0, 8'h44, 0, 0);
    step(1, 0, 8'h55, 0, 0);
    chk("R10 first frame count", avail_cnt, 4);
    step(1, 1, 8'h80, 0, 0);
    chk("R10 count with two frames", avail_cnt, 4);
    for (int i = 0; i < 4; i++) step(0, 0, 8'h00, 1, 0);
    chk("R10 next frame count", avail_cnt, 3);
    chk("R10 next frame head", rd_data, 8'h44);
    drain();
    step(0, 0, 8'h00, 0, 1);

    // R6: sweep every fill threshold
    for (int fl = 0; fl < 64; fl++) begin
      fill_lvl = 6'(fl);
      step(0, 0, 8'h00, 0, 1);
      for (int k = 0; k < DEPTH; k++) step(1, 0, 8'(k + fl), 0, 0);
      chk("R6 fill flag at full", irq_fill, 1);
      step(0, 0, 8'h00, 0, 1);
      drain();
      step(0, 0, 8'h00, 0, 1);
    end
    fill_lvl = 6'd0;

    // R7/R8: payload overrun, discard, merged status
    for (int k = 0; k < DEPTH; k++) step(1, 0, 8'(k), 0, 0);
    step(1, 0, 8'hEE, 0, 0);
    chk("R7 overrun irq", irq_ovr, 1);
    chk("R7 count held", avail_cnt, 64);
    step(0, 0, 8'h00, 1, 0);
    step(1, 0, 8'hAB, 0, 0);
    chk("R8 payload discarded after overrun", avail_cnt, 63);
    step(1, 1, 8'h80, 0, 0);
    chk("R8 status merged not appended", avail_cnt, 63);
    for (int k = 0; k < 62; k++) step(0, 0, 8'h00, 1, 0);
    chk("R8 merged value", rd_data, 8'hA0);
    chk("R8 merged tag", rd_is_stat, 1);
    drain();
    step(0, 0, 8'h00, 0, 1);

    // R7: status write at full, then payload onto a status slot
    for (int k = 0; k < DEPTH; k++) step(1, 0, 8'h5A, 0, 0);
    step(1, 1, 8'h40, 0, 0);
    step(1, 0, 8'h77, 0, 0);
    step(1, 1, 8'h01, 0, 0);
    for (int k = 0; k < 63; k++) step(0, 0, 8'h00, 1, 0);
    chk("R7 status slot value", rd_data, 8'h61);
    drain();

    // R9: clear versus simultaneous set
    step(0, 0, 8'h00, 0, 1);
    step(1, 1, 8'h00, 0, 0);
    step(1, 1, 8'h00, 0, 1);
    chk("R9 set wins over clear", irq_eof, 1);
    step(0, 0, 8'h00, 0, 1);
    chk("R9 clear", irq_eof, 0);
    chk("R9 sticky ovr cleared", irq_ovr, 0);
    drain();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule